// File: doc/BRIEF.md
# Result Memory with Minimum and Maximum Magnitude

This block keeps the four most recently saved game results. Each result is a 13-bit signed value with a sign flag on top and a three-digit BCD magnitude under it. A store pulse moves every saved result one place older, loses the oldest one and puts the incoming result in the newest place. A clear pulse empties the memory.

The memory always offers three values drawn from its contents: the newest saved result, the saved result with the smallest magnitude and the saved result with the largest magnitude. The sign plays no part in these comparisons. A 2-bit view select puts one of these, or the live incoming result, on the single output. Places that have not been filled since reset or since the last clear are left out of every comparison. When the memory is empty, every stored view reads zero.

Top module: `result_memory_minmax`

## Requirements
- R1: After reset the memory holds no result, and views 1, 2 and 3 all output 13'h0000.
- R2: With view select 0, the output equals `result_in` in the same cycle, whatever `store` and `clear` do.
- R3: A `store` pulse with `clear` low saves `result_in` as the newest result. From the next cycle, view 1 outputs it unchanged.
- R4: Only the four newest results are kept. A fifth store drops the result saved first, and that result no longer takes part in the minimum or the maximum.
- R5: View 2 outputs the saved result whose magnitude (bits 11:0, compared as an unsigned 12-bit number) is smallest. Its sign bit is kept.
- R6: View 3 outputs the saved result whose magnitude (bits 11:0, unsigned) is largest. Its sign bit is kept.
- R7: When saved results tie on magnitude, the one saved most recently is chosen for view 2 and for view 3.
- R8: Unfilled places never take part. With one to three results saved, the minimum and maximum are taken over only those results.
- R9: A `clear` pulse empties the memory, so views 1 to 3 read zero from the next cycle. `clear` wins over a `store` given in the same cycle.
- R10: Encoding: bit 12 of a result is the sign (1 means negative) and bits 11:0 are three BCD digits. View select values are 0 for live, 1 for newest, 2 for minimum and 3 for maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| result_in | input | 13 | Live game result: sign bit and BCD magnitude |
| store | input | 1 | One-cycle pulse that saves `result_in` |
| clear | input | 1 | One-cycle pulse that empties the memory |
| sel_out | input | 2 | View select |
| result_out | output | 13 | Selected view |

## Verification
The hardest case to reach from the ports is a magnitude tie between saved results of opposite sign. It has to occur while the memory is partly full or has just evicted an entry, because only then can a wrong choice of tie winner or a stale place show up on the output. The stimulus draws magnitudes from a set of only three values with random signs, and it mixes in clears, so ties happen in every fill state. After every store, all four views are compared with a model that recomputes the minimum and maximum from the bench's own copy of the four newest results.

// File: rtl/rmem_pkg.sv
package rmem_pkg;

    localparam int MAG_W = 12;
    localparam int RES_W = MAG_W + 1;
    localparam int SLOTS = 4;

    typedef logic [MAG_W-1:0] mag_t;

    typedef struct packed {
        logic sgn;
        mag_t mag;
    } res_t;

    typedef struct packed {
        logic vld;
        res_t res;
    } slot_t;

    typedef enum logic [1:0] {
        VIEW_LIVE = 2'd0,
        VIEW_LAST = 2'd1,
        VIEW_MIN  = 2'd2,
        VIEW_MAX  = 2'd3
    } view_e;

    localparam res_t RES_ZERO = '0;

    // candidate replaces the running best when it is valid and at least as good
    function automatic logic prefer_cand(slot_t cand, slot_t best, logic find_max);
        if (!cand.vld) return 1'b0;
        if (!best.vld) return 1'b1;
        if (find_max) return cand.res.mag >= best.res.mag;
        return cand.res.mag <= best.res.mag;
    endfunction

    function automatic res_t slot_value(slot_t s);
        return s.vld ? s.res : RES_ZERO;
    endfunction

endpackage

// File: rtl/rmem_slot_chain.sv
module rmem_slot_chain
    import rmem_pkg::*;
#(
    parameter int DEPTH = SLOTS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   store,
    input  logic                   clear,
    input  res_t                   din,
    output slot_t [DEPTH-1:0]      slots
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clear)
                    slots[i] <= '0;
                else if (store)
                    slots[i] <= '{vld: 1'b1, res: din};
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || clear)
                    slots[i] <= '0;
                else if (store)
                    slots[i] <= slots[i-1];
            end

            AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
                (store && !clear) |=> slots[i] == $past(slots[i-1])); // R4

            AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (rst)
                slots[i].vld |-> slots[i-1].vld); // R8
        end

        AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
            clear |=> !slots[i].vld); // R9
    end

    AST_STORE_NEWEST: assert property (@(posedge clk) disable iff (rst)
        (store && !clear) |=> (slots[0].vld && slots[0].res == $past(din))); // R3

endmodule

// File: rtl/rmem_extreme.sv
module rmem_extreme
    import rmem_pkg::*;
#(
    parameter int DEPTH    = SLOTS,
    parameter bit FIND_MAX = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t [DEPTH-1:0] slots,
    output slot_t             best
);

    // stage[k] holds the best of slots k..DEPTH-1; newer slots sit at lower index
    slot_t stage [DEPTH+1];

    assign stage[DEPTH] = '0;

    for (genvar i = DEPTH - 1; i >= 0; i--) begin : g_stage
        assign stage[i] = prefer_cand(slots[i], stage[i+1], FIND_MAX) ? slots[i] : stage[i+1];

        if (FIND_MAX) begin : g_max_chk
            AST_EXTREME_BOUND: assert property (@(posedge clk) disable iff (rst)
                slots[i].vld |-> (best.vld && best.res.mag >= slots[i].res.mag)); // R6
        end else begin : g_min_chk
            AST_EXTREME_BOUND: assert property (@(posedge clk) disable iff (rst)
                slots[i].vld |-> (best.vld && best.res.mag <= slots[i].res.mag)); // R5
        end
    end

    assign best = stage[0];

    AST_EMPTY_NOBEST: assert property (@(posedge clk) disable iff (rst)
        !slots[0].vld |-> !best.vld); // R8

endmodule

// File: rtl/rmem_view_mux.sv
module rmem_view_mux
    import rmem_pkg::*;
(
    input  view_e sel,
    input  res_t  live,
    input  slot_t newest,
    input  slot_t minv,
    input  slot_t maxv,
    output res_t  dout
);

    always_comb begin
        unique case (sel)
            VIEW_LIVE: dout = live;
            VIEW_LAST: dout = slot_value(newest);
            VIEW_MIN:  dout = slot_value(minv);
            VIEW_MAX:  dout = slot_value(maxv);
            default:   dout = RES_ZERO;
        endcase
    end

endmodule

// File: rtl/result_memory_minmax.sv
module result_memory_minmax
    import rmem_pkg::*;
#(
    parameter int DEPTH = SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] result_in,
    input  logic             store,
    input  logic             clear,
    input  logic [1:0]       sel_out,
    output logic [RES_W-1:0] result_out
);

    localparam int N_EXT = 2;

    res_t              din;
    res_t              dout;
    slot_t [DEPTH-1:0] slots;
    slot_t             ext [N_EXT];

    assign din        = res_t'(result_in);
    assign result_out = dout;

    rmem_slot_chain #(.DEPTH(DEPTH)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .store (store),
        .clear (clear),
        .din   (din),
        .slots (slots)
    );

    // index 0 finds the minimum, index 1 the maximum
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        rmem_extreme #(.DEPTH(DEPTH), .FIND_MAX(k == 1)) u_ext (
            .clk   (clk),
            .rst   (rst),
            .slots (slots),
            .best  (ext[k])
        );
    end

    rmem_view_mux u_mux (
        .sel    (view_e'(sel_out)),
        .live   (din),
        .newest (slots[0]),
        .minv   (ext[0]),
        .maxv   (ext[1]),
        .dout   (dout)
    );

    AST_LIVE_PASS: assert property (@(posedge clk) disable iff (rst)
        (sel_out == 2'd0) |-> (result_out == result_in)); // R2

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!slots[0].vld && sel_out != 2'd0) |-> (result_out == '0)); // R1

    AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
        ext[0].vld |-> (ext[1].vld && ext[0].res.mag <= ext[1].res.mag)); // R5

endmodule

// File: tb/result_memory_minmax_test.sv
module result_memory_minmax_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] result_in = '0;
    logic        store = 1'b0;
    logic        clear = 1'b0;
    logic [1:0]  sel_out = 2'd0;
    logic [12:0] result_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [12:0] m [4];
    int cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    result_memory_minmax uut (
        .clk(clk), .rst(rst), .result_in(result_in), .store(store),
        .clear(clear), .sel_out(sel_out), .result_out(result_out)
    );

    task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [12:0] expect_view(int v);
        logic [12:0] best;
        bit have;
        have = 0;
        best = '0;
        if (v == 0) return result_in;
        if (cnt == 0) return 13'h0;
        if (v == 1) return m[0];
        for (int i = cnt - 1; i >= 0; i--) begin
            if (!have || (v == 2 ? m[i][11:0] <= best[11:0] : m[i][11:0] >= best[11:0])) begin
                best = m[i];
                have = 1;
            end
        end
        return best;
    endfunction

    task automatic look(input int v, input string tag);
        sel_out = 2'(v);
        #1;
        check(tag, result_out, expect_view(v));
    endtask

    task automatic look_all();
        look(1, "R3 newest");
        look(2, "R5 minimum");
        look(3, "R6 maximum");
    endtask

    task automatic model_store(input logic [12:0] v);
        for (int i = 3; i > 0; i--) m[i] = m[i-1];
        m[0] = v;
        if (cnt < 4) cnt++;
    endtask

    task automatic do_store(input logic [12:0] v);
        @(negedge clk);
        result_in = v;
        store = 1'b1;
        @(negedge clk);
        store = 1'b0;
        model_store(v);
    endtask

    task automatic do_clear(input bit with_store);
        @(negedge clk);
        clear = 1'b1;
        store = with_store;
        @(negedge clk);
        clear = 1'b0;
        store = 1'b0;
        cnt = 0;
    endtask

    function automatic logic [12:0] rnd_val(bit narrow);
        logic [3:0] d2, d1, d0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d0 = 4'(lfsr[3:0] % (narrow ? 3 : 10));
        d1 = narrow ? 4'd0 : 4'(lfsr[7:4] % 10);
        d2 = narrow ? 4'd0 : 4'(lfsr[11:8] % 10);
        return {lfsr[15], d2, d1, d0};
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: empty after reset
        for (int v = 1; v < 4; v++) begin
            sel_out = 2'(v); #1;
            check("R1 reset empty", result_out, 13'h0);
        end

        // R2: live passthrough, also while a store is pending
        result_in = 13'h1987; sel_out = 2'd0; #1;
        check("R2 live", result_out, 13'h1987);
        store = 1'b1; result_in = 13'h0042; #1;
        check("R2 live during store", result_out, 13'h0042);
        @(negedge clk); store = 1'b0; model_store(13'h0042);
        look_all();

        // R8: single entry is both min and max; R10 sign kept (negative 0.05)
        do_clear(0);
        do_store(13'h1005);
        look(2, "R8 single min");
        look(3, "R8 single max");
        check("R10 sign kept", result_out, 13'h1005);

        // R4: five stores, the first one (largest) evicted
        do_clear(0);
        do_store(13'h0999);
        do_store(13'h1100);
        do_store(13'h0250);
        do_store(13'h1003);
        look(3, "R6 max before evict");
        do_store(13'h0400);
        look(3, "R4 eviction max");
        check("R4 eviction max value", result_out, 13'h0400);
        look(2, "R4 eviction min");
        check("R5 mixed sign min", result_out, 13'h1003);

        // R7: tie on magnitude, newer wins
        do_clear(0);
        do_store(13'h0123);
        do_store(13'h1123);
        look(2, "R7 tie min");
        check("R7 tie min newer", result_out, 13'h1123);
        look(3, "R7 tie max");
        check("R7 tie max newer", result_out, 13'h1123);

        // R9: clear empties; clear wins over simultaneous store
        do_clear(0);
        for (int v = 1; v < 4; v++) begin
            sel_out = 2'(v); #1;
            check("R9 clear empties", result_out, 13'h0);
        end
        do_clear(1);
        for (int v = 1; v < 4; v++) begin
            sel_out = 2'(v); #1;
            check("R9 clear beats store", result_out, 13'h0);
        end

        // sweep: wide and narrow magnitudes, clears mixed in
        for (int n = 0; n < 600; n++) begin
            if (n % 37 == 36) begin
                do_clear(0);
                look_all();
            end
            do_store(rnd_val(n >= 300));
            look_all();
            look(0, "R2 live sweep");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule